// File: doc/BRIEF.md
# Multi-Channel Shared-Memory FIFO Engine

This block links a set of small on-chip item FIFOs, which face a coprocessor, to circular buffers that software keeps in shared memory. Each channel points at a state block in memory. The state block holds a lock word and a status word. The status word packs the buffer's read index in bits [31:16] and its fill count in bits [15:0], both counted in items. A channel moves data in one of two directions, fixed by a parameter mask. Channels toward the coprocessor pull items out of memory. Channels from the coprocessor push items into memory.

The engine is a bus master with a single outstanding request. When several enabled channels need service, it picks one round-robin. It then runs five transactions in a fixed order:

- a test-and-set read of the lock word;
- a read of the status word;
- one data transfer of a full item;
- a write of the updated status word;
- a write of zero to the lock word.

If the lock is busy, or if the buffer holds nothing to move, the channel backs off for a programmable number of cycles. The same back-off applies after an error response. All data paths use valid/ready. A sender holds its payload stable while valid is high and ready is low. A transfer happens on any cycle where both are high.

Top module: `mwf_engine`

## Requirements
- R1: After reset, no bus request is valid, no toward-coprocessor output is valid, and every from-coprocessor input is ready.
- R2: A toward-coprocessor channel asks for service only while its local FIFO is empty. A from-coprocessor channel asks only while its local FIFO is full.
- R3: A serviced transfer issues exactly five requests in this order:
  - a test-and-set read (`m_req_lock`=1) of the lock address, where a returned zero means the lock was taken;
  - a read of the status address;
  - the item read or write, with `m_req_bytes` equal to the channel's width in bytes;
  - a write of the new status word to the status address;
  - a write of zero to the lock address.
- R4: The item address is base + slot × width.
  - A reader uses slot = read index. It then writes back {index+1 wrapped to 0 at depth, count−1}.
  - A writer uses slot = (index+count) modulo depth. It then writes back {index, count+1}.
- R5: When several channels are eligible, grants rotate round-robin, starting after the channel served last. The channel searched first after reset is channel 0.
- R6: A channel whose `cfg_run` bit is low issues no request.
- R7: If a reader sees count 0, or a writer sees count ≥ depth, the data and status steps are skipped. The lock is released and the channel backs off.
- R8: A nonzero lock read ends the attempt with no further request. The same channel tries again no sooner than `cfg_wait` cycles later.
- R9: An error response after the lock is taken aborts the transfer. The lock is still released, and neither the local FIFO nor the status word is changed.
- R10: A request stays stable until it is accepted. No new request is raised before the response to the previous one.
- R11: A toward-coprocessor output holds its data while valid is high and ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_run | input | NCH | Per-channel enable |
| cfg_lock_addr | input | NCH×AW | Lock word byte address |
| cfg_stat_addr | input | NCH×AW | Status word byte address |
| cfg_base_addr | input | NCH×AW | Buffer base byte address |
| cfg_depth | input | NCH×16 | Buffer depth in items |
| cfg_width | input | NCH×8 | Item size in bytes, a multiple of 4 |
| cfg_wait | input | WW | Back-off interval in cycles |
| m_req_valid | output | 1 | Request valid |
| m_req_ready | input | 1 | Request accepted |
| m_req_write | output | 1 | 1 = write, 0 = read |
| m_req_lock | output | 1 | Test-and-set read |
| m_req_addr | output | AW | Byte address |
| m_req_bytes | output | 8 | Transfer size in bytes |
| m_req_wdata | output | DW | Write data |
| m_rsp_valid | input | 1 | Response valid |
| m_rsp_ready | output | 1 | Response accepted |
| m_rsp_err | input | 1 | Error response |
| m_rsp_rdata | input | DW | Read data |
| cp_out_valid | output | NCH | Item to coprocessor valid |
| cp_out_ready | input | NCH | Coprocessor takes item |
| cp_out_data | output | NCH×DW | Item to coprocessor |
| cp_in_valid | input | NCH | Item from coprocessor valid |
| cp_in_ready | output | NCH | Engine takes item |
| cp_in_data | input | NCH×DW | Item from coprocessor |

## Verification
The bound checker covers the cycle-level rules on every cycle:

- request stability under stall and a single outstanding request (R10);
- the lock access being a read;
- coprocessor output hold (R11).

Only the directed scenarios can show the protocol-level behaviour:

- the exact five-step sequence and the status arithmetic with index wrap;
- the round-robin order;
- skipping on an empty or full buffer;
- the back-off gap after a busy lock;
- the abort path on an error response.

These depend on memory contents and on timing across many transactions.

// File: rtl/mwf_pkg.sv
package mwf_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LOCK_Q, ST_LOCK_R, ST_STAT_Q, ST_STAT_R,
    ST_DATA_Q, ST_DATA_R, ST_UPD_Q, ST_UPD_R, ST_REL_Q, ST_REL_R
  } mwf_state_e;

  // status word: [31:16] read index, [15:0] fill count (items)
  function automatic logic has_work(input logic to_cp, input logic [31:0] stat,
                                    input logic [15:0] depth);
    if (to_cp) return stat[15:0] != 16'd0;
    else       return stat[15:0] < depth;
  endfunction

  function automatic logic [15:0] slot_of(input logic to_cp, input logic [31:0] stat,
                                          input logic [15:0] depth);
    logic [16:0] sum;
    sum = {1'b0, stat[31:16]} + {1'b0, stat[15:0]};
    if (to_cp) return stat[31:16];
    if (sum >= {1'b0, depth}) sum = sum - {1'b0, depth};
    return sum[15:0];
  endfunction

  function automatic logic [31:0] next_stat(input logic to_cp, input logic [31:0] stat,
                                            input logic [15:0] depth);
    logic [15:0] nidx;
    nidx = stat[31:16] + 16'd1;
    if (nidx == depth) nidx = 16'd0;
    if (to_cp) return {nidx, stat[15:0] - 16'd1};
    else       return {stat[31:16], stat[15:0] + 16'd1};
  endfunction
endpackage

// File: rtl/mwf_item_fifo.sv
module mwf_item_fifo #(
  parameter int DW    = 64,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic do_in, do_out;

  assign in_ready  = cnt != CW'(DEPTH);
  assign out_valid = cnt != '0;
  assign out_data  = store[rp];
  assign do_in     = in_valid && in_ready;
  assign do_out    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_in)  wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_out) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_in) - CW'(do_out);
    end
  end

  always_ff @(posedge clk) if (do_in) store[wp] <= in_data;
endmodule

// File: rtl/mwf_rr_arb.sv
module mwf_rr_arb #(
  parameter int N  = 3,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic          gnt_valid,
  output logic [CW-1:0] gnt_idx
);
  logic [CW-1:0] last;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = last;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last) + k) % N;
      if (!gnt_valid && req[idx]) begin
        gnt_valid = 1'b1;
        gnt_idx   = CW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last <= CW'(N - 1);
    else if (take && gnt_valid) last <= gnt_idx;
  end
endmodule

// File: rtl/mwf_seq.sv
module mwf_seq
  import mwf_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 32,
  parameter int DW  = 64,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gnt_valid,
  input  logic [CW-1:0] gnt_idx,
  output logic          take,
  output logic [CW-1:0] cur,
  input  logic          is_to,
  input  logic [AW-1:0] c_lock,
  input  logic [AW-1:0] c_stat,
  input  logic [AW-1:0] c_base,
  input  logic [15:0]   c_depth,
  input  logic [7:0]    c_width,
  input  logic [DW-1:0] head_data,
  output logic          m_req_valid,
  input  logic          m_req_ready,
  output logic          m_req_write,
  output logic          m_req_lock,
  output logic [AW-1:0] m_req_addr,
  output logic [7:0]    m_req_bytes,
  output logic [DW-1:0] m_req_wdata,
  input  logic          m_rsp_valid,
  output logic          m_rsp_ready,
  input  logic          m_rsp_err,
  input  logic [DW-1:0] m_rsp_rdata,
  output logic          push_stb,
  output logic          pop_stb,
  output logic          bo_load
);
  mwf_state_e st;
  logic [31:0] stat_r;
  logic        fail_r;
  logic [23:0] off;
  logic        rsp_ok;

  assign take   = (st == ST_IDLE) && gnt_valid;
  assign rsp_ok = m_rsp_valid && !m_rsp_err;
  assign off    = 24'(slot_of(is_to, stat_r, c_depth)) * 24'(c_width);

  always_comb begin
    m_req_valid = 1'b0; m_req_write = 1'b0; m_req_lock = 1'b0;
    m_req_addr  = c_lock; m_req_bytes = 8'd4; m_req_wdata = '0;
    unique case (st)
      ST_LOCK_Q: begin m_req_valid = 1'b1; m_req_lock = 1'b1; end
      ST_STAT_Q: begin m_req_valid = 1'b1; m_req_addr = c_stat; end
      ST_DATA_Q: begin
        m_req_valid = 1'b1; m_req_write = !is_to;
        m_req_addr  = c_base + AW'(off);
        m_req_bytes = c_width; m_req_wdata = head_data;
      end
      ST_UPD_Q: begin
        m_req_valid = 1'b1; m_req_write = 1'b1; m_req_addr = c_stat;
        m_req_wdata = DW'(next_stat(is_to, stat_r, c_depth));
      end
      ST_REL_Q: begin m_req_valid = 1'b1; m_req_write = 1'b1; end
      default: ;
    endcase
  end

  assign m_rsp_ready = (st == ST_LOCK_R) || (st == ST_STAT_R) || (st == ST_DATA_R)
                    || (st == ST_UPD_R)  || (st == ST_REL_R);
  assign push_stb = (st == ST_DATA_R) && rsp_ok && is_to;
  assign pop_stb  = (st == ST_DATA_R) && rsp_ok && !is_to;
  assign bo_load  = ((st == ST_LOCK_R) && m_rsp_valid && (m_rsp_err || m_rsp_rdata[31:0] != 32'd0))
                 || ((st == ST_REL_R) && m_rsp_valid && fail_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; cur <= '0; stat_r <= '0; fail_r <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (gnt_valid) begin cur <= gnt_idx; fail_r <= 1'b0; st <= ST_LOCK_Q; end
        ST_LOCK_Q: if (m_req_ready) st <= ST_LOCK_R;
        ST_LOCK_R: if (m_rsp_valid)
          st <= (m_rsp_err || m_rsp_rdata[31:0] != 32'd0) ? ST_IDLE : ST_STAT_Q;
        ST_STAT_Q: if (m_req_ready) st <= ST_STAT_R;
        ST_STAT_R: if (m_rsp_valid) begin
          stat_r <= m_rsp_rdata[31:0];
          if (m_rsp_err || !has_work(is_to, m_rsp_rdata[31:0], c_depth)) begin
            fail_r <= 1'b1; st <= ST_REL_Q;
          end else st <= ST_DATA_Q;
        end
        ST_DATA_Q: if (m_req_ready) st <= ST_DATA_R;
        ST_DATA_R: if (m_rsp_valid) begin
          if (m_rsp_err) begin fail_r <= 1'b1; st <= ST_REL_Q; end
          else st <= ST_UPD_Q;
        end
        ST_UPD_Q: if (m_req_ready) st <= ST_UPD_R;
        ST_UPD_R: if (m_rsp_valid) begin
          if (m_rsp_err) fail_r <= 1'b1;
          st <= ST_REL_Q;
        end
        ST_REL_Q: if (m_req_ready) st <= ST_REL_R;
        ST_REL_R: if (m_rsp_valid) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mwf_engine.sv
module mwf_engine #(
  parameter int       NCH     = 3,
  parameter bit [NCH-1:0] TO_MASK = 3'b101,
  parameter int       AW      = 32,
  parameter int       DW      = 64,
  parameter int       FDEPTH  = 2,
  parameter int       WW      = 16,
  localparam int      CW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          cfg_run,
  input  logic [NCH-1:0][AW-1:0]  cfg_lock_addr,
  input  logic [NCH-1:0][AW-1:0]  cfg_stat_addr,
  input  logic [NCH-1:0][AW-1:0]  cfg_base_addr,
  input  logic [NCH-1:0][15:0]    cfg_depth,
  input  logic [NCH-1:0][7:0]     cfg_width,
  input  logic [WW-1:0]           cfg_wait,
  output logic                    m_req_valid,
  input  logic                    m_req_ready,
  output logic                    m_req_write,
  output logic                    m_req_lock,
  output logic [AW-1:0]           m_req_addr,
  output logic [7:0]              m_req_bytes,
  output logic [DW-1:0]           m_req_wdata,
  input  logic                    m_rsp_valid,
  output logic                    m_rsp_ready,
  input  logic                    m_rsp_err,
  input  logic [DW-1:0]           m_rsp_rdata,
  output logic [NCH-1:0]          cp_out_valid,
  input  logic [NCH-1:0]          cp_out_ready,
  output logic [NCH-1:0][DW-1:0]  cp_out_data,
  input  logic [NCH-1:0]          cp_in_valid,
  output logic [NCH-1:0]          cp_in_ready,
  input  logic [NCH-1:0][DW-1:0]  cp_in_data
);
  logic [NCH-1:0]         need, elig;
  logic [NCH-1:0][DW-1:0] head;
  logic                   gnt_valid, take, push_stb, pop_stb, bo_load;
  logic [CW-1:0]          gnt_idx, cur;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam bit IS_TO = TO_MASK[i];
    logic          f_in_v, f_in_r, f_out_v, f_out_r;
    logic [DW-1:0] f_in_d, f_out_d;
    logic [WW-1:0] bo_cnt;

    assign f_in_v  = IS_TO ? (push_stb && cur == CW'(i)) : cp_in_valid[i];
    assign f_in_d  = IS_TO ? m_rsp_rdata : cp_in_data[i];
    assign f_out_r = IS_TO ? cp_out_ready[i] : (pop_stb && cur == CW'(i));

    mwf_item_fifo #(.DW(DW), .DEPTH(FDEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .in_valid(f_in_v), .in_ready(f_in_r), .in_data(f_in_d),
      .out_valid(f_out_v), .out_ready(f_out_r), .out_data(f_out_d));

    assign cp_out_valid[i] = IS_TO && f_out_v;
    assign cp_out_data[i]  = IS_TO ? f_out_d : '0;
    assign cp_in_ready[i]  = !IS_TO && f_in_r;
    assign head[i]         = f_out_d;
    assign need[i]         = IS_TO ? !f_out_v : !f_in_r;
    assign elig[i]         = cfg_run[i] && need[i] && (bo_cnt == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) bo_cnt <= '0;
      else if (bo_load && cur == CW'(i)) bo_cnt <= cfg_wait;
      else if (bo_cnt != '0) bo_cnt <= bo_cnt - 1'b1;
    end
  end

  mwf_rr_arb #(.N(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(elig), .take(take),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx));

  mwf_seq #(.NCH(NCH), .AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .take(take), .cur(cur),
    .is_to(TO_MASK[cur]),
    .c_lock(cfg_lock_addr[cur]), .c_stat(cfg_stat_addr[cur]),
    .c_base(cfg_base_addr[cur]), .c_depth(cfg_depth[cur]), .c_width(cfg_width[cur]),
    .head_data(head[cur]),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_write(m_req_write),
    .m_req_lock(m_req_lock), .m_req_addr(m_req_addr), .m_req_bytes(m_req_bytes),
    .m_req_wdata(m_req_wdata), .m_rsp_valid(m_rsp_valid), .m_rsp_ready(m_rsp_ready),
    .m_rsp_err(m_rsp_err), .m_rsp_rdata(m_rsp_rdata),
    .push_stb(push_stb), .pop_stb(pop_stb), .bo_load(bo_load));
endmodule

// File: rtl/mwf_chk.sv
module mwf_chk #(
  parameter int NCH = 3,
  parameter int AW  = 32,
  parameter int DW  = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   m_req_valid,
  input logic                   m_req_ready,
  input logic                   m_req_write,
  input logic                   m_req_lock,
  input logic [AW-1:0]          m_req_addr,
  input logic [DW-1:0]          m_req_wdata,
  input logic                   m_rsp_ready,
  input logic [NCH-1:0]         cp_out_valid,
  input logic [NCH-1:0]         cp_out_ready,
  input logic [NCH-1:0][DW-1:0] cp_out_data
);
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req_valid && !m_req_ready) |=> (m_req_valid && $stable(m_req_addr)
      && $stable(m_req_write) && $stable(m_req_wdata)));

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_req_valid && m_rsp_ready));

  assert_gap_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req_valid && m_req_ready) |=> !m_req_valid);

  assert_lock_is_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req_valid && m_req_lock) |-> !m_req_write);

  for (genvar i = 0; i < NCH; i++) begin : g_out
    assert_out_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_out_valid[i] && !cp_out_ready[i]) |=> (cp_out_valid[i] && $stable(cp_out_data[i])));
  end
endmodule

bind mwf_engine mwf_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_req_valid(m_req_valid), .m_req_ready(m_req_ready),
  .m_req_write(m_req_write), .m_req_lock(m_req_lock), .m_req_addr(m_req_addr),
  .m_req_wdata(m_req_wdata), .m_rsp_ready(m_rsp_ready), .cp_out_valid(cp_out_valid),
  .cp_out_ready(cp_out_ready), .cp_out_data(cp_out_data));

// File: tb/sim_mwf_engine.sv
`timescale 1ns/1ps
module sim_mwf_engine;
  localparam int NCH = 3, AW = 32, DW = 64, WW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NCH-1:0]         cfg_run = '0;
  logic [NCH-1:0][AW-1:0] cfg_lock_addr, cfg_stat_addr, cfg_base_addr;
  logic [NCH-1:0][15:0]   cfg_depth;
  logic [NCH-1:0][7:0]    cfg_width;
  logic [WW-1:0]          cfg_wait = '0;
  logic m_req_valid, m_req_ready, m_req_write, m_req_lock, m_rsp_ready;
  logic [AW-1:0] m_req_addr;
  logic [7:0]    m_req_bytes;
  logic [DW-1:0] m_req_wdata;
  logic          m_rsp_valid, m_rsp_err;
  logic [DW-1:0] m_rsp_rdata;
  logic [NCH-1:0] cp_out_valid, cp_in_ready;
  logic [NCH-1:0] cp_out_ready = '0, cp_in_valid = '0;
  logic [NCH-1:0][DW-1:0] cp_out_data;
  logic [NCH-1:0][DW-1:0] cp_in_data = '0;

  mwf_engine #(.NCH(NCH), .TO_MASK(3'b101), .AW(AW), .DW(DW), .FDEPTH(2), .WW(WW)) u0 (.*);

  // memory model
  logic [31:0] mem [256];
  logic        poke_en = 1'b0;
  logic [7:0]  poke_a;
  logic [31:0] poke_d;
  logic        lock_stuck = 1'b0, err_on = 1'b0;
  logic [AW-1:0] err_addr = '0;
  logic [AW-1:0] lg_addr [256];
  logic          lg_we [256];
  logic          lg_lock [256];
  logic [DW-1:0] lg_wd [256];
  logic [7:0]    lg_bytes [256];
  int            lg_cyc [256];
  int            n_req = 0, cyc = 0;

  assign m_req_ready = !m_rsp_valid;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_rsp_valid <= 1'b0; m_rsp_err <= 1'b0; m_rsp_rdata <= '0;
    end else begin
      if (poke_en) mem[poke_a] <= poke_d;
      if (m_rsp_valid && m_rsp_ready) m_rsp_valid <= 1'b0;
      if (m_req_valid && m_req_ready) begin
        automatic logic [7:0] ix = m_req_addr[9:2];
        automatic logic e = err_on && (m_req_addr == err_addr);
        if (n_req < 256) begin
          lg_addr[n_req] <= m_req_addr; lg_we[n_req] <= m_req_write;
          lg_lock[n_req] <= m_req_lock; lg_wd[n_req] <= m_req_wdata;
          lg_bytes[n_req] <= m_req_bytes; lg_cyc[n_req] <= cyc;
        end
        n_req <= n_req + 1;
        m_rsp_valid <= 1'b1; m_rsp_err <= e; m_rsp_rdata <= '0;
        if (!e) begin
          if (m_req_lock) begin
            m_rsp_rdata <= lock_stuck ? 64'd1 : {32'd0, mem[ix]};
            if (!lock_stuck) mem[ix] <= 32'd1;
          end else if (m_req_write) begin
            mem[ix] <= m_req_wdata[31:0];
            if (m_req_bytes == 8'd8) mem[ix + 8'd1] <= m_req_wdata[63:32];
          end else m_rsp_rdata <= {mem[ix + 8'd1], mem[ix]};
        end
      end
    end
  end

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input int byte_addr, input logic [31:0] d);
    @(negedge clk); poke_en = 1'b1; poke_a = 8'(byte_addr >> 2); poke_d = d;
    @(negedge clk); poke_en = 1'b0;
  endtask

  task automatic wait_reqs(input int target, input int lim);
    for (int k = 0; k < lim && n_req < target; k++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 req idle", 64'(m_req_valid), 64'd0);
    chk("R1 out idle", 64'(cp_out_valid), 64'd0);
    chk("R1 in ready", 64'(cp_in_ready), 64'b010);
  endtask

  task automatic t_read;
    int b;
    poke(32'h004, {16'd1, 16'd2}); poke(32'h048, 32'hA1); poke(32'h04C, 32'hB1);
    b = n_req;
    @(negedge clk); cfg_run[0] = 1'b1;
    wait_reqs(b + 5, 200);
    chk("R10 five requests", 64'(n_req - b), 64'd5);
    chk("R3 step1 lock tas", {lg_lock[b], lg_we[b], 32'(lg_addr[b])}, {1'b1, 1'b0, 32'h000});
    chk("R3 step2 stat read", {lg_we[b+1], 32'(lg_addr[b+1])}, {1'b0, 32'h004});
    chk("R4 data addr", {lg_we[b+2], 32'(lg_addr[b+2])}, {1'b0, 32'h048});
    chk("R4 data bytes", 64'(lg_bytes[b+2]), 64'd8);
    chk("R4 stat write", {lg_we[b+3], 32'(lg_addr[b+3]), lg_wd[b+3][31:0]}, {1'b1, 32'h004, 32'h0002_0001});
    chk("R3 release", {lg_we[b+4], 32'(lg_addr[b+4]), lg_wd[b+4][31:0]}, {1'b1, 32'h000, 32'h0});
    chk("R4 mem stat", 64'(mem[1]), 64'h0002_0001);
    chk("R3 lock free", 64'(mem[0]), 64'd0);
    repeat (3) @(negedge clk);
    chk("R11 out held", {63'(cp_out_valid[0]), 1'b0}, {63'd1, 1'b0});
    chk("R11 out data", cp_out_data[0], 64'h0000_00B1_0000_00A1);
    cfg_run[0] = 1'b0; cp_out_ready[0] = 1'b1;
    @(negedge clk); cp_out_ready[0] = 1'b0;
    chk("R2 popped", 64'(cp_out_valid[0]), 64'd0);
  endtask

  task automatic t_write;
    int b;
    poke(32'h104, {16'd3, 16'd1}); poke(32'h140, 32'h0);
    cfg_run[1] = 1'b1; b = n_req;
    cp_in_valid[1] = 1'b1; cp_in_data[1] = 64'hDEAD0000_00000011;
    @(negedge clk); cp_in_data[1] = 64'hDEAD0000_00000022;
    @(negedge clk); cp_in_valid[1] = 1'b0;
    wait_reqs(b + 5, 200);
    chk("R2 full triggers", 64'(n_req - b), 64'd5);
    chk("R4 write wrap addr", {lg_we[b+2], 32'(lg_addr[b+2])}, {1'b1, 32'h140});
    chk("R4 write bytes", 64'(lg_bytes[b+2]), 64'd4);
    chk("R4 mem item", 64'(mem[8'h50]), 64'h11);
    chk("R4 mem stat", 64'(mem[8'h41]), 64'h0003_0002);
    chk("R2 in ready again", 64'(cp_in_ready[1]), 64'd1);
    cfg_run[1] = 1'b0;
  endtask

  task automatic t_rr;
    int b;
    poke(32'h004, {16'd3, 16'd2}); poke(32'h204, {16'd0, 16'd2});
    cfg_wait = 16'd1000; cp_out_ready = 3'b101; b = n_req;
    @(negedge clk); cfg_run = 3'b101;
    wait_reqs(b + 20, 400);
    cfg_run = '0;
    chk("R5 first ch2", 64'(lg_addr[b]), 64'h200);
    chk("R5 second ch0", 64'(lg_addr[b+5]), 64'h000);
    chk("R5 third ch2", 64'(lg_addr[b+10]), 64'h200);
    chk("R5 fourth ch0", 64'(lg_addr[b+15]), 64'h000);
    chk("R4 slot3 addr", 64'(lg_addr[b+7]), 64'h058);
    chk("R4 wrap slot0", 64'(lg_addr[b+17]), 64'h040);
    repeat (20) @(negedge clk);
    chk("R4 wrapped stat", 64'(mem[1]), 64'h0001_0000);
    repeat (1100) @(negedge clk);
    cp_out_ready = '0; cfg_wait = '0;
  endtask

  task automatic t_idle;
    int b;
    poke(32'h204, {16'd2, 16'd1});
    b = n_req; cfg_run = 3'b010;
    repeat (40) @(negedge clk);
    chk("R2 not full no request", 64'(n_req - b), 64'd0);
    cfg_run = '0;
    repeat (40) @(negedge clk);
    chk("R6 stopped no request", 64'(n_req - b), 64'd0);
  endtask

  task automatic t_empty;
    int b;
    cfg_wait = 16'd60; b = n_req;
    @(negedge clk); cfg_run[0] = 1'b1;
    repeat (30) @(negedge clk);
    chk("R7 three requests", 64'(n_req - b), 64'd3);
    chk("R7 release", {lg_we[b+2], 32'(lg_addr[b+2])}, {1'b1, 32'h000});
    chk("R7 stat unchanged", 64'(mem[1]), 64'h0001_0000);
    cfg_run[0] = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  task automatic t_busy;
    int b;
    poke(32'h004, {16'd0, 16'd1});
    lock_stuck = 1'b1; cfg_wait = 16'd40; b = n_req;
    @(negedge clk); cfg_run[0] = 1'b1;
    wait_reqs(b + 2, 300);
    cfg_run[0] = 1'b0;
    chk("R8 only lock reads", {lg_lock[b], lg_lock[b+1]}, 2'b11);
    chk("R8 retry gap", 64'(lg_cyc[b+1] - lg_cyc[b] >= 40), 64'd1);
    lock_stuck = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  task automatic t_err;
    int b;
    poke(32'h004, {16'd1, 16'd1});
    err_on = 1'b1; err_addr = 32'h048; cfg_wait = 16'd60; b = n_req;
    @(negedge clk); cfg_run[0] = 1'b1;
    repeat (30) @(negedge clk);
    cfg_run[0] = 1'b0;
    chk("R9 four requests", 64'(n_req - b), 64'd4);
    chk("R9 release", {lg_we[b+3], 32'(lg_addr[b+3]), lg_wd[b+3][31:0]}, {1'b1, 32'h000, 32'h0});
    chk("R9 stat unchanged", 64'(mem[1]), 64'h0001_0001);
    chk("R9 lock free", 64'(mem[0]), 64'd0);
    chk("R9 fifo unchanged", 64'(cp_out_valid[0]), 64'd0);
    err_on = 1'b0;
  endtask

  initial begin
    cfg_lock_addr = {32'h200, 32'h100, 32'h000};
    cfg_stat_addr = {32'h204, 32'h104, 32'h004};
    cfg_base_addr = {32'h240, 32'h140, 32'h040};
    cfg_depth     = {16'd4, 16'd4, 16'd4};
    cfg_width     = {8'd8, 8'd4, 8'd8};
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_read(); t_write(); t_rr(); t_idle(); t_empty(); t_busy(); t_err();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(60000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule